// File: doc/BRIEF.md
# Packed Lane Shift and Rotate Unit

This unit shifts or rotates a 64-bit packed operand whose contents are read as four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. One shift count applies to every lane. Bits never cross from one lane into another. The unit supports logical left, logical right, arithmetic right and rotate right. Along with the result it produces a status word that holds a negative flag and a zero flag for each lane.

The unit has a single output register. On a clock edge where `en` is high, the register captures the shifted result and the status word built from that result. On an edge where `en` is low, the register keeps its value. Results therefore appear one cycle after the inputs are presented. The count is wide enough to express values at or above the widest lane. Such counts follow fixed rules: logical shifts flush the lane to zero, arithmetic shifts fill the lane with its sign, and rotates reduce the count modulo the lane width.

Top module: `lane_shifter`

## Requirements
- R1: While `rst_n` is low, `result` and `flags` are zero. `rst_n` clears them asynchronously.
- R2: On an edge with `en` high, the outputs take the value for the inputs present at that edge. On an edge with `en` low, both outputs hold their previous values.
- R3: `lane_sel` selects the lane width: 00 is 16 bits, 01 is 32 bits, and 10 or 11 is 64 bits. Lane k occupies bits [k*W+W-1 : k*W], and no bit ever moves from one lane into another.
- R4: `op` 00 is a logical left shift. Zeros enter at each lane's low end, and bits that pass the lane's top are lost.
- R5: `op` 01 is a logical right shift. Zeros enter at each lane's high end.
- R6: `op` 10 is an arithmetic right shift. Each lane is refilled with copies of its own most significant bit.
- R7: `op` 11 is a rotate right. Bits that leave a lane's low end re-enter at that lane's high end, and the effective count is the count modulo the lane width.
- R8: A count of zero returns the operand unchanged for all four operations.
- R9: For a count at or above the lane width, a logical shift in either direction gives an all-zero lane, and an arithmetic shift gives a lane filled with its sign bit.
- R10: `flags` holds one 4-bit nibble per lane, with lane k at bits [4k+3:4k]. Bit 4k+3 is N and equals the lane's top result bit. Bit 4k+2 is Z and is set when the lane's result is zero. Bits 4k+1 (carry) and 4k (overflow) are always 0. Nibbles above the active lane count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the output register |
| operand | input | 64 | Packed source data |
| count | input | 7 | Shift or rotate amount, shared by all lanes |
| lane_sel | input | 2 | Lane width select |
| op | input | 2 | Operation select |
| result | output | 64 | Registered shifted or rotated data |
| flags | output | 16 | Registered per-lane N/Z/C/V status |

## Verification
The operands have bit patterns that differ from lane to lane, so a lane unit wired to the wrong slice shows up as a wrong value in `result`. A mux that leaks or mixes lane widths shows up in the same way, one cycle after capture. A wrong flag-packing state appears in the same cycle as its result, because the N and Z bits must agree with the registered result bits next to them. A faulty enable or hold path shows up as a `result` that changes on a cycle after a capture where `en` was low. The tests cover counts of zero, one less than the lane width, exactly the lane width and beyond it, in every lane mode, because faults in the edge handling appear only at those counts.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned CNT_W   = 7;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned MIN_LW  = 16;
  localparam int unsigned MAX_LN  = DATA_W / MIN_LW;
  localparam int unsigned FLAG_W  = MAX_LN * NIB_W;

  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_SAR = 2'b10,
    OP_ROR = 2'b11
  } shift_op_e;

  typedef enum logic [1:0] {
    LW_16  = 2'b00,
    LW_32  = 2'b01,
    LW_64  = 2'b10,
    LW_64X = 2'b11
  } lane_w_e;
endpackage

// File: rtl/lsh_lane_unit.sv
module lsh_lane_unit #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 7
) (
  input  logic [W-1:0]     din,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       op,
  output logic [W-1:0]     dout
);
  import lsh_pkg::*;

  localparam int unsigned IDX_W = $clog2(W);

  logic             past_edge;
  logic [IDX_W-1:0] rot_amt;
  logic [2*W-1:0]   rot_wide;
  logic [W-1:0]     left_v;
  logic [W-1:0]     right_v;
  logic [W-1:0]     arith_v;
  logic [W-1:0]     sign_fill;

  assign past_edge = (int'(cnt) >= int'(W));
  assign rot_amt   = cnt[IDX_W-1:0];
  assign rot_wide  = {din, din} >> rot_amt;
  assign left_v    = din << cnt;
  assign right_v   = din >> cnt;
  assign arith_v   = W'($signed(din) >>> cnt);
  assign sign_fill = {W{din[W-1]}};

  always_comb begin
    unique case (shift_op_e'(op))
      OP_SHL:  dout = past_edge ? '0 : left_v;
      OP_SHR:  dout = past_edge ? '0 : right_v;
      OP_SAR:  dout = past_edge ? sign_fill : arith_v;
      OP_ROR:  dout = rot_wide[W-1:0];
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/lsh_flag_pack.sv
module lsh_flag_pack #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned MIN_LW = 16
) (
  input  logic [DATA_W-1:0]             res,
  input  logic [1:0]                    lane_sel,
  output logic [(DATA_W/MIN_LW)*4-1:0]  flags
);
  import lsh_pkg::*;

  localparam int unsigned N16 = DATA_W / MIN_LW;
  localparam int unsigned N32 = DATA_W / (2*MIN_LW);
  localparam int unsigned FW  = N16 * 4;

  logic [FW-1:0] f16, f32, f64;

  for (genvar k = 0; k < N16; k++) begin : g_f16
    localparam int unsigned LO = k * MIN_LW;
    assign f16[4*k +: 4] = {res[LO+MIN_LW-1], ~|res[LO +: MIN_LW], 2'b00};
  end

  for (genvar k = 0; k < N16; k++) begin : g_f32
    if (k < N32) begin : g_act
      localparam int unsigned LO = k * 2 * MIN_LW;
      assign f32[4*k +: 4] = {res[LO+2*MIN_LW-1], ~|res[LO +: 2*MIN_LW], 2'b00};
    end else begin : g_idle
      assign f32[4*k +: 4] = 4'b0000;
    end
  end

  assign f64 = {{(FW-4){1'b0}}, res[DATA_W-1], ~|res, 2'b00};

  always_comb begin
    unique case (lane_w_e'(lane_sel))
      LW_16:   flags = f16;
      LW_32:   flags = f32;
      default: flags = f64;
    endcase
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int unsigned DATA_W = lsh_pkg::DATA_W,
  parameter int unsigned CNT_W  = lsh_pkg::CNT_W,
  parameter int unsigned MIN_LW = lsh_pkg::MIN_LW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [DATA_W-1:0]            operand,
  input  logic [CNT_W-1:0]             count,
  input  logic [1:0]                   lane_sel,
  input  logic [1:0]                   op,
  output logic [DATA_W-1:0]            result,
  output logic [(DATA_W/MIN_LW)*4-1:0] flags
);
  import lsh_pkg::*;

  localparam int unsigned W16 = MIN_LW;
  localparam int unsigned W32 = 2 * MIN_LW;
  localparam int unsigned N16 = DATA_W / W16;
  localparam int unsigned N32 = DATA_W / W32;
  localparam int unsigned FW  = N16 * 4;

  logic [DATA_W-1:0] res16, res32, res64;
  logic [DATA_W-1:0] res_nxt;
  logic [FW-1:0]     flg_nxt;
  logic [DATA_W-1:0] res_q;
  logic [FW-1:0]     flg_q;

  for (genvar k = 0; k < N16; k++) begin : g_l16
    lsh_lane_unit #(.W(W16), .CNT_W(CNT_W)) u_lane (
      .din  (operand[k*W16 +: W16]),
      .cnt  (count),
      .op   (op),
      .dout (res16[k*W16 +: W16])
    );
  end

  for (genvar k = 0; k < N32; k++) begin : g_l32
    lsh_lane_unit #(.W(W32), .CNT_W(CNT_W)) u_lane (
      .din  (operand[k*W32 +: W32]),
      .cnt  (count),
      .op   (op),
      .dout (res32[k*W32 +: W32])
    );
  end

  lsh_lane_unit #(.W(DATA_W), .CNT_W(CNT_W)) u_l64 (
    .din  (operand),
    .cnt  (count),
    .op   (op),
    .dout (res64)
  );

  always_comb begin
    unique case (lane_w_e'(lane_sel))
      LW_16:   res_nxt = res16;
      LW_32:   res_nxt = res32;
      default: res_nxt = res64;
    endcase
  end

  lsh_flag_pack #(.DATA_W(DATA_W), .MIN_LW(MIN_LW)) u_flags (
    .res      (res_nxt),
    .lane_sel (lane_sel),
    .flags    (flg_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (en) begin
      res_q <= res_nxt;
      flg_q <= flg_nxt;
    end
  end

  assign result = res_q;
  assign flags  = flg_q;
endmodule

// File: rtl/lsh_checker.sv
module lsh_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic [63:0] operand,
  input logic [6:0]  count,
  input logic [1:0]  lane_sel,
  input logic [1:0]  op,
  input logic [63:0] result,
  input logic [15:0] flags
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result) && $stable(flags)));

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count == 7'd0) |=> (result == $past(operand)));

  p_wide_logical_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == 2'b00 || op == 2'b01) && count >= 7'd64) |=> (result == 64'd0));

  p_nflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lane_sel == 2'b00) |=>
      (flags[3] == result[15] && flags[7] == result[31] &&
       flags[11] == result[47] && flags[15] == result[63]));

  p_zflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lane_sel == 2'b00) |=>
      (flags[2] == (result[15:0] == 16'd0) && flags[6] == (result[31:16] == 16'd0) &&
       flags[10] == (result[47:32] == 16'd0) && flags[14] == (result[63:48] == 16'd0)));

  p_upper_nibbles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lane_sel == 2'b01) |=> (flags[15:8] == 8'd0));

  p_cv_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & 16'h3333) == 16'd0));
endmodule

bind lane_shifter lsh_checker u_chk (.*);

// File: tb/lane_shifter_test.sv
module lane_shifter_test;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [63:0] operand;
  logic [6:0]  count;
  logic [1:0]  lane_sel;
  logic [1:0]  op;
  logic [63:0] result;
  logic [15:0] flags;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 0;

  lane_shifter uut (
    .clk(clk), .rst_n(rst_n), .en(en), .operand(operand), .count(count),
    .lane_sel(lane_sel), .op(op), .result(result), .flags(flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [79:0] model(input logic [1:0] o, input logic [1:0] ls,
                                         input int c, input logic [63:0] x);
    int w;
    logic [63:0] res;
    logic [15:0] fl;
    w   = (ls == 2'b00) ? 16 : (ls == 2'b01) ? 32 : 64;
    res = '0;
    fl  = '0;
    for (int k = 0; k < 64 / w; k++) begin
      logic [63:0] msk, ln, r, sgn;
      int ra;
      msk = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
      ln  = (x >> (k * w)) & msk;
      sgn = (ln >> (w - 1)) & 64'd1;
      case (o)
        2'b00: r = (c >= w) ? 64'd0 : ((ln << c) & msk);
        2'b01: r = (c >= w) ? 64'd0 : (ln >> c);
        2'b10: r = (c >= w) ? (sgn != 0 ? msk : 64'd0)
                            : ((ln >> c) | (sgn != 0 ? (msk & ~(msk >> c)) : 64'd0));
        default: begin
          ra = c % w;
          r  = (ra == 0) ? ln : (((ln >> ra) | (ln << (w - ra))) & msk);
        end
      endcase
      res = res | (r << (k * w));
      fl[4*k+3] = ((r >> (w - 1)) & 64'd1) != 0;
      fl[4*k+2] = (r == 64'd0);
    end
    return {fl, res};
  endfunction

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual result=%h flags=%h expected result=%h flags=%h",
               tag, act[63:0], act[79:64], exp[63:0], exp[79:64]);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [1:0] ls, input int c,
                       input logic [63:0] x);
    @(negedge clk);
    op = o; lane_sel = ls; count = 7'(c); operand = x; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic run(input string tag, input logic [1:0] o, input logic [1:0] ls,
                     input int c, input logic [63:0] x);
    apply(o, ls, c, x);
    chk(tag, {flags, result}, model(o, ls, c, x));
  endtask

  task automatic run_lit(input string tag, input logic [1:0] o, input logic [1:0] ls,
                         input int c, input logic [63:0] x, input logic [63:0] want);
    apply(o, ls, c, x);
    chk(tag, {16'd0, result}, {16'd0, want});
    chk(tag, {flags, result}, model(o, ls, c, x));
  endtask

  task automatic test_reset();
    rst_n = 1'b0; en = 1'b1; operand = 64'hDEAD_BEEF_1234_5678;
    count = 7'd3; lane_sel = 2'b00; op = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {flags, result}, 80'd0);
    en = 1'b0; rst_n = 1'b1;
  endtask

  task automatic test_hold();
    logic [79:0] snap;
    run("R2 capture", 2'b01, 2'b00, 3, 64'h1234_5678_9ABC_DEF0);
    snap = {flags, result};
    operand = 64'hFFFF_0000_FFFF_0000; op = 2'b11; count = 7'd5;
    repeat (2) @(negedge clk);
    chk("R2 hold with en low", {flags, result}, snap);
  endtask

  task automatic test_shl();
    run_lit("R3 R4 lane isolation left 16", 2'b00, 2'b00, 4,
            64'hFFFF_FFFF_FFFF_FFFF, 64'hFFF0_FFF0_FFF0_FFF0);
    run("R4 left 32 by 31", 2'b00, 2'b01, 31, 64'h0000_0003_8000_0001);
    run("R4 left 64 by 63", 2'b00, 2'b10, 63, 64'h0000_0000_0000_0003);
  endtask

  task automatic test_shr();
    run_lit("R5 right 32 by 31", 2'b01, 2'b01, 31,
            64'h8000_0000_8000_0000, 64'h0000_0001_0000_0001);
    run("R5 R3 right 16 mode 11 as 64", 2'b01, 2'b11, 20, 64'hF00F_1234_8765_ABCD);
  endtask

  task automatic test_sar();
    run_lit("R6 arith 16 by 4", 2'b10, 2'b00, 4,
            64'h8000_7FFF_F000_0010, 64'hF800_07FF_FF00_0001);
    run("R6 arith 32 by 15", 2'b10, 2'b01, 15, 64'h9234_5678_7234_5678);
    run("R6 arith 64 by 62", 2'b10, 2'b10, 62, 64'h8000_0000_0000_0000);
  endtask

  task automatic test_ror();
    run_lit("R7 rotate 16 by 1", 2'b11, 2'b00, 1,
            64'h0001_0001_0001_0001, 64'h8000_8000_8000_8000);
    run_lit("R7 rotate 16 by 17 modulo", 2'b11, 2'b00, 17,
            64'h0001_0001_0001_0001, 64'h8000_8000_8000_8000);
    run_lit("R7 rotate 64 by 8", 2'b11, 2'b10, 8,
            64'h0123_4567_89AB_CDEF, 64'hEF01_2345_6789_ABCD);
    run("R7 rotate 32 by 33", 2'b11, 2'b01, 33, 64'h8000_0001_C000_0003);
  endtask

  task automatic test_zero_count();
    for (int o = 0; o < 4; o++) begin
      run_lit("R8 count zero", 2'(o), 2'(o % 3), 0,
              64'hA5A5_0F0F_8001_7FFE, 64'hA5A5_0F0F_8001_7FFE);
    end
  endtask

  task automatic test_wide();
    run_lit("R9 logical right 64 by 64", 2'b01, 2'b10, 64,
            64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    run_lit("R9 logical left 16 by 16", 2'b00, 2'b00, 16,
            64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    run_lit("R9 arith 32 by 40", 2'b10, 2'b01, 40,
            64'h8000_0000_7000_0000, 64'hFFFF_FFFF_0000_0000);
    run_lit("R9 arith 64 by 127", 2'b10, 2'b10, 127,
            64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic test_flags();
    apply(2'b01, 2'b00, 0, 64'h8000_0000_0001_0000);
    chk("R10 flags 16 lanes", {flags, 64'd0}, {16'h8404, 64'd0});
    apply(2'b00, 2'b01, 0, 64'd0);
    chk("R10 flags 32 lanes", {flags, 64'd0}, {16'h0044, 64'd0});
    apply(2'b10, 2'b10, 3, 64'h8000_0000_0000_0000);
    chk("R10 flags 64 lane", {flags, 64'd0}, {16'h0008, 64'd0});
  endtask

  initial begin
    test_reset();
    test_hold();
    test_shl();
    test_shr();
    test_sar();
    test_ror();
    test_zero_count();
    test_wide();
    test_flags();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule